// File: doc/BRIEF.md
# Dual-Port Address Collision Arbiter

This block sits beside a two-port memory and watches the requests of its left and right ports. Each port brings a chip enable, a write enable and an address. If both ports are enabled on the same address, the block picks one owner of that location. It drives an active-low busy flag to the other port and closes that port's internal write gate. The memory array and the data paths are outside the block. The memory only consumes the two write-gate outputs and ignores its raw write strobes.

Arbitration is synchronous. A port counts as "settled" when it was enabled on the same address in the previous clock cycle. When a collision starts, a settled port wins over a port that has just arrived. If neither port is settled, or both are, the left port wins. The winner is kept in a small state register for as long as the match lasts, so a collision is never handed back and forth. The busy and gate outputs follow the current inputs within the same cycle. This lets the losing port's write be suppressed in the cycle the collision appears.

Top module: `dpa_arb`

## Requirements
- R1: When the two addresses differ, `l_busy_n` and `r_busy_n` are both 1 in that cycle.
- R2: When the addresses are equal but either enable is 0, both busy outputs are 1 in that cycle.
- R3: A collision starts when both enables are 1 on equal addresses and no owner is held. If exactly one port held the same enable and address in the previous cycle, the other port's busy output is 0 in that same cycle.
- R4: A collision can start with neither port settled, including the first cycle after reset. In that case `r_busy_n` is 0 and `l_busy_n` is 1.
- R5: `l_busy_n` and `r_busy_n` are never 0 at the same time.
- R6: For each port, the write gate (`l_wr_ok`, `r_wr_ok`) is 1 exactly when that port's enable and write enable are 1 and its busy output is 1. A busy port's write is therefore suppressed.
- R7: While the match persists from cycle to cycle, the same port stays busy. Changes on the winning port, such as toggling its write enable, do not move ownership.
- R8: In the cycle the collision ends, the blocked port's busy output returns to 1. This happens on an address mismatch or when either enable drops. A later collision is arbitrated afresh.
- R9: While the synchronous active-high `rst` is 1, both busy outputs are 1. Reset also clears the held owner and the settled history.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| l_en | input | 1 | Left port enable, active high |
| l_we | input | 1 | Left port write request, active high |
| l_addr | input | ADDR_W | Left port address |
| r_en | input | 1 | Right port enable, active high |
| r_we | input | 1 | Right port write request, active high |
| r_addr | input | ADDR_W | Right port address |
| l_busy_n | output | 1 | Left port blocked, active low |
| r_busy_n | output | 1 | Right port blocked, active low |
| l_wr_ok | output | 1 | Left write allowed into the memory |
| r_wr_ok | output | 1 | Right write allowed into the memory |

## Verification
A wrong held owner shows up as a busy output that flips sides in the middle of a persistent collision. It is visible in the very next cycle of the match. A wrong settled history appears only at the start of a collision, as the wrong port flagged in that first cycle. The bench therefore creates collisions from a small address pool, with staggered and simultaneous arrivals and long holds. Each cycle it compares both busy flags and both write gates against a model of its own.

// File: rtl/dpa_pkg.sv
package dpa_pkg;

    localparam int NUM_PORTS = 2;
    localparam int PORT_L    = 0;
    localparam int PORT_R    = 1;

    typedef enum logic [1:0] {
        SIDE_NONE  = 2'b00,
        SIDE_LEFT  = 2'b01,
        SIDE_RIGHT = 2'b10
    } side_e;

    // Winner of a freshly starting collision: a settled port beats a new one,
    // otherwise the left port takes the tie.
    function automatic side_e pick_fresh(input logic l_settled, input logic r_settled);
        if (r_settled && !l_settled) return SIDE_RIGHT;
        return SIDE_LEFT;
    endfunction

    // Side that must be blocked given the current owner.
    function automatic logic is_blocked(input side_e owner, input int port);
        if (port == PORT_L) return owner == SIDE_RIGHT;
        return owner == SIDE_LEFT;
    endfunction

endpackage

// File: rtl/dpa_req_track.sv
module dpa_req_track #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [ADDR_W-1:0] addr,
    output logic              settled
);
    logic              en_q;
    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= 1'b0;
            addr_q <= '0;
        end else begin
            en_q   <= en;
            addr_q <= addr;
        end
    end

    assign settled = en && en_q && (addr == addr_q);
endmodule

// File: rtl/dpa_match.sv
module dpa_match #(
    parameter int ADDR_W = 10
) (
    input  logic              l_en,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic              r_en,
    input  logic [ADDR_W-1:0] r_addr,
    output logic              hit
);
    assign hit = l_en && r_en && (l_addr == r_addr);
endmodule

// File: rtl/dpa_owner.sv
module dpa_owner
    import dpa_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 hit,
    input  logic [NUM_PORTS-1:0] settled,
    output side_e                owner
);
    side_e held_q;

    always_comb begin
        if (!hit)
            owner = SIDE_NONE;
        else if (held_q != SIDE_NONE)
            owner = held_q;
        else
            owner = pick_fresh(settled[PORT_L], settled[PORT_R]);
    end

    always_ff @(posedge clk) begin
        if (rst) held_q <= SIDE_NONE;
        else     held_q <= owner;
    end
endmodule

// File: rtl/dpa_arb.sv
module dpa_arb
    import dpa_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              l_en,
    input  logic              l_we,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic              r_en,
    input  logic              r_we,
    input  logic [ADDR_W-1:0] r_addr,
    output logic              l_busy_n,
    output logic              r_busy_n,
    output logic              l_wr_ok,
    output logic              r_wr_ok
);
    logic [NUM_PORTS-1:0]             en_v;
    logic [NUM_PORTS-1:0]             we_v;
    logic [NUM_PORTS-1:0][ADDR_W-1:0] addr_v;
    logic [NUM_PORTS-1:0]             settled_v;
    logic [NUM_PORTS-1:0]             blocked_v;
    logic [NUM_PORTS-1:0]             gate_v;
    logic                             hit;
    side_e                            owner;

    assign en_v[PORT_L]   = l_en;
    assign en_v[PORT_R]   = r_en;
    assign we_v[PORT_L]   = l_we;
    assign we_v[PORT_R]   = r_we;
    assign addr_v[PORT_L] = l_addr;
    assign addr_v[PORT_R] = r_addr;

    dpa_match #(.ADDR_W(ADDR_W)) u_match (
        .l_en   (l_en),
        .l_addr (l_addr),
        .r_en   (r_en),
        .r_addr (r_addr),
        .hit    (hit)
    );

    dpa_owner u_owner (
        .clk     (clk),
        .rst     (rst),
        .hit     (hit),
        .settled (settled_v),
        .owner   (owner)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        dpa_req_track #(.ADDR_W(ADDR_W)) u_track (
            .clk     (clk),
            .rst     (rst),
            .en      (en_v[p]),
            .addr    (addr_v[p]),
            .settled (settled_v[p])
        );
        assign blocked_v[p] = !rst && is_blocked(owner, p);
        assign gate_v[p]    = en_v[p] && we_v[p] && !blocked_v[p];
    end

    assign l_busy_n = !blocked_v[PORT_L];
    assign r_busy_n = !blocked_v[PORT_R];
    assign l_wr_ok  = gate_v[PORT_L];
    assign r_wr_ok  = gate_v[PORT_R];
endmodule

// File: rtl/dpa_arb_chk.sv
module dpa_arb_chk #(
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst,
    input logic              l_en,
    input logic              l_we,
    input logic [ADDR_W-1:0] l_addr,
    input logic              r_en,
    input logic              r_we,
    input logic [ADDR_W-1:0] r_addr,
    input logic              l_busy_n,
    input logic              r_busy_n,
    input logic              l_wr_ok,
    input logic              r_wr_ok
);
    logic same;
    assign same = l_en && r_en && (l_addr == r_addr);

    p_apart_free_r1: assert property (@(posedge clk) disable iff (rst)
        (l_addr != r_addr) |-> (l_busy_n && r_busy_n));

    p_idle_free_r2: assert property (@(posedge clk) disable iff (rst)
        (!l_en || !r_en) |-> (l_busy_n && r_busy_n));

    p_one_loser_r5: assert property (@(posedge clk) disable iff (rst)
        !(!l_busy_n && !r_busy_n));

    p_gate_left_r6: assert property (@(posedge clk) disable iff (rst)
        l_wr_ok == (l_en && l_we && l_busy_n));

    p_gate_right_r6: assert property (@(posedge clk) disable iff (rst)
        r_wr_ok == (r_en && r_we && r_busy_n));

    p_keep_right_r7: assert property (@(posedge clk) disable iff (rst)
        (same && $past(same) && $past(!r_busy_n)) |-> !r_busy_n);

    p_keep_left_r7: assert property (@(posedge clk) disable iff (rst)
        (same && $past(same) && $past(!l_busy_n)) |-> !l_busy_n);

    p_collide_flags_r3: assert property (@(posedge clk) disable iff (rst)
        same |-> (!l_busy_n || !r_busy_n));

    p_reset_free_r9: assert property (@(posedge clk)
        rst |-> (l_busy_n && r_busy_n));
endmodule

bind dpa_arb dpa_arb_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .l_en     (l_en),
    .l_we     (l_we),
    .l_addr   (l_addr),
    .r_en     (r_en),
    .r_we     (r_we),
    .r_addr   (r_addr),
    .l_busy_n (l_busy_n),
    .r_busy_n (r_busy_n),
    .l_wr_ok  (l_wr_ok),
    .r_wr_ok  (r_wr_ok)
);

// File: tb/dpa_arb_bench.sv
module dpa_arb_bench;
    localparam int CLK_P  = 10;
    localparam int ADDR_W = 10;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              l_en = 1'b0, l_we = 1'b0, r_en = 1'b0, r_we = 1'b0;
    logic [ADDR_W-1:0] l_addr = '0, r_addr = '0;
    logic              l_busy_n, r_busy_n, l_wr_ok, r_wr_ok;

    int checks = 0;
    int errors = 0;

    // reference state: 0 none, 1 left owns, 2 right owns
    int                m_owner = 0;
    logic              m_pel = 1'b0, m_per = 1'b0;
    logic [ADDR_W-1:0] m_pal = '0, m_par = '0;

    always #(CLK_P/2) clk = ~clk;

    dpa_arb #(.ADDR_W(ADDR_W)) u_dpa_arb (
        .clk(clk), .rst(rst),
        .l_en(l_en), .l_we(l_we), .l_addr(l_addr),
        .r_en(r_en), .r_we(r_we), .r_addr(r_addr),
        .l_busy_n(l_busy_n), .r_busy_n(r_busy_n),
        .l_wr_ok(l_wr_ok), .r_wr_ok(r_wr_ok)
    );

    function automatic logic m_hit();
        return l_en && r_en && (l_addr == r_addr);
    endfunction

    function automatic int m_winner();
        logic sl, sr;
        if (!m_hit()) return 0;
        if (m_owner != 0) return m_owner;
        sl = l_en && m_pel && (l_addr == m_pal);
        sr = r_en && m_per && (r_addr == m_par);
        if (sr && !sl) return 2;
        return 1;
    endfunction

    function automatic string m_tag();
        logic sl, sr;
        if (rst) return "R9";
        if (l_addr != r_addr) return "R1";
        if (!l_en || !r_en) return "R2";
        if (m_owner != 0) return "R7";
        sl = l_en && m_pel && (l_addr == m_pal);
        sr = r_en && m_per && (r_addr == m_par);
        if (sl != sr) return "R3";
        return "R4";
    endfunction

    task automatic chk(input string tag, input logic got, input logic exp, input string what);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%b expected=%b at %0t", tag, what, got, exp, $time);
        end
    endtask

    // Drive inputs, check at the falling edge, advance the model at the rising edge.
    task automatic step(input logic rs, input logic le, input logic lw, input int la,
                        input logic re, input logic rw, input int ra, input string tag);
        int    w;
        logic  eb_l, eb_r;
        string t;
        rst = rs; l_en = le; l_we = lw; l_addr = ADDR_W'(la);
        r_en = re; r_we = rw; r_addr = ADDR_W'(ra);
        @(negedge clk);
        w    = rst ? 0 : m_winner();
        eb_l = !(w == 2);
        eb_r = !(w == 1);
        t    = (tag == "") ? m_tag() : tag;
        chk(t, l_busy_n, eb_l, "l_busy_n");
        chk(t, r_busy_n, eb_r, "r_busy_n");
        chk("R5", l_busy_n || r_busy_n, 1'b1, "one side free");
        chk("R6", l_wr_ok, l_en && l_we && eb_l, "l_wr_ok");
        chk("R6", r_wr_ok, r_en && r_we && eb_r, "r_wr_ok");
        @(posedge clk);
        if (rst) begin
            m_owner = 0; m_pel = 0; m_per = 0; m_pal = '0; m_par = '0;
        end else begin
            m_owner = w;
            m_pel = l_en; m_per = r_en; m_pal = l_addr; m_par = r_addr;
        end
        #1;
    endtask

    initial begin
        #(CLK_P * 200000);
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'd4242);
        @(posedge clk); #1;
        // R9: reset with a collision on the inputs keeps both free
        step(1, 1, 1, 5, 1, 1, 5, "R9");
        step(1, 1, 1, 5, 1, 1, 5, "R9");
        // R4: first cycle after reset, both arrive together -> right loses
        step(0, 1, 1, 5, 1, 1, 5, "R4");
        // R7: hold, toggle winner write enable, ownership stays
        step(0, 1, 0, 5, 1, 1, 5, "R7");
        step(0, 1, 1, 5, 1, 1, 5, "R7");
        step(0, 1, 0, 5, 1, 0, 5, "R7");
        // R8: right releases, busy clears same cycle
        step(0, 1, 1, 5, 0, 1, 5, "R8");
        // R3: left settled at 7, right arrives -> right busy
        step(0, 1, 0, 7, 0, 0, 0, "R1");
        step(0, 1, 0, 7, 1, 1, 7, "R3");
        step(0, 1, 1, 9, 1, 1, 7, "R8");
        // R3/R6: right settled at 9, left arrives writing -> left busy, gated
        step(0, 0, 0, 9, 1, 1, 9, "R2");
        step(0, 1, 1, 9, 1, 1, 9, "R3");
        step(0, 1, 1, 9, 1, 1, 9, "R7");
        // R8: new arbitration after release: both new again -> tie to left
        step(0, 0, 0, 9, 0, 0, 9, "R8");
        step(0, 1, 1, 3, 1, 1, 3, "R4");
        // R1: differing addresses
        step(0, 1, 1, 3, 1, 1, 4, "R1");
        // random phase on a tiny address pool
        for (int i = 0; i < 3000; i++) begin
            logic rs;
            rs = ($urandom_range(0, 199) == 0);
            step(rs, ($urandom_range(0, 3) != 0), $urandom_range(0, 1), $urandom_range(0, 2),
                 ($urandom_range(0, 3) != 0), $urandom_range(0, 1), $urandom_range(0, 2), "");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule